// File: doc/BRIEF.md
# Interrupt Controller Host Command Port

This block is the host-facing register port of an eight-line interrupt controller. A narrow bus with one address bit, separate write and read strobes and a byte of data reaches it. Writes at the command address either restart the setup sequence, change operating modes, or issue end-of-service and priority-rotation commands. Writes at the data address carry the later setup words, and once setup is complete they load the line mask.

The port owns the mask, the in-service register, the rotation base (the line that currently has the highest priority), the vector base and the mode flags. Request capture and priority resolution live in a separate resolver. That resolver supplies the current request register and the winning line, and it tells the port when a line has been acknowledged so that its in-service bit can be set. In the other direction, the port tells the resolver which request bit to drop after a poll read, when a setup restart must clear its requests, and when its interrupt output must be re-evaluated.

Top module: `irq_cmd_port`

## Requirements
- R1: After reset, every register output is zero: mask, in-service, rotation base, vector base, all mode flags, read data, and all strobes. `init_busy` is also low.
- R2: A command-address write with bit 4 set restarts setup. The next cycle shows `init_busy` high and `init_clr` pulsed. Mask, in-service, rotation base, vector base and all mode flags read zero.
- R3: During setup, the first data-address write loads the vector base from bits 7..3, with the low three bits reading zero. The second data-address write advances to a fourth word only if bit 0 of the restart byte was set; otherwise setup ends. The fourth word sets nested mode from bit 4 and auto-end-of-service from bit 1, and then ends setup.
- R4: Outside setup, a data-address write loads the mask with the written byte.
- R5: A command-address write with bit 4 clear and bit 3 set is a mode write. Bit 2 set arms poll mode. Bit 1 set lets bit 0 choose the read source (1 = in-service, 0 = request). Bit 6 set lets bit 5 set or clear special mask. A flag whose enable bit is clear keeps its value.
- R6: A command write with bits 4 and 3 clear and code (bits 7..5) 4 sets rotate-on-auto-end. Code 0 clears it. Neither changes the in-service register or the rotation base.
- R7: Code 1 clears the in-service bit of highest priority, searching from the rotation-base line upward with wrap. Code 5 does the same and also sets the rotation base to that line plus 1. With no in-service bit set, neither command changes anything.
- R8: Code 3 clears the in-service bit named by bits 2..0. Code 7 clears that bit and sets the rotation base to the named line plus 1. Code 6 only sets the rotation base to bits 2..0 plus 1. Code 2 leaves the in-service register, the rotation base and the mask unchanged.
- R9: A read while poll mode is armed returns the resolver's winning line, or 7 if the resolver shows no winner. It clears that line's in-service bit, pulses that line's bit on `req_clr` for one cycle, and disarms poll mode.
- R10: Outside poll mode, a read returns its data in the cycle after the read strobe. A command-address read returns the in-service register when the read source is 1 and the request register when it is 0. A data-address read returns the mask.
- R11: `upd_strobe` is high in the cycle after a setup restart, a mask load, a code 1, 3, 5, 6 or 7 command, or a poll read. It stays low after code 0, 2 and 4 commands and after mode writes.
- R12: An acknowledge on `svc_set_en` sets the in-service bit of `svc_set_line` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| req_vec | input | 8 | Request register from the resolver |
| win_valid | input | 1 | Resolver has a winning line |
| win_line | input | 3 | Winning line number |
| svc_set_en | input | 1 | Acknowledge: set an in-service bit |
| svc_set_line | input | 3 | Line being acknowledged |
| mask_reg | output | 8 | Line mask |
| isr_reg | output | 8 | In-service register |
| rot_base | output | 3 | Line that has the highest priority |
| vec_base | output | 8 | Vector base (low three bits zero) |
| auto_eoi | output | 1 | Auto-end-of-service mode |
| nested_mode | output | 1 | Nested mode flag |
| rot_auto_eoi | output | 1 | Rotate on auto-end flag |
| special_mask | output | 1 | Special mask flag |
| poll_mode | output | 1 | Poll armed |
| init_busy | output | 1 | Setup sequence in progress |
| req_clr | output | 8 | One-cycle request clear for the resolver |
| init_clr | output | 1 | One-cycle pulse on setup restart |
| upd_strobe | output | 1 | Re-evaluate interrupt output |

## Verification
On every cycle, the assertions check that a setup restart clears the held state, that mask loads land outside setup, that rotate-on-auto-end and specific rotation take their values, that a poll read disarms poll mode, that a request clear only follows a poll read, and that mask loads raise the update strobe. Only the bench's scenarios can show the order in which the setup words are consumed, the wrap-around priority search used by end-of-service, the no-change cases (code 2, an empty in-service register, disabled mode bits) and the value returned by a poll read.

// File: rtl/irq_cmd_pkg.sv
// Shared types and command codes for the interrupt command port.
// Assumes an eight-line controller driven by byte-wide commands.
package irq_cmd_pkg;

    typedef enum logic [1:0] {
        SEQ_RUN = 2'd0,
        SEQ_W2  = 2'd1,
        SEQ_W3  = 2'd2,
        SEQ_W4  = 2'd3
    } seq_st_t;

    localparam logic [2:0] CMD_RAEOI_OFF = 3'd0;
    localparam logic [2:0] CMD_EOI       = 3'd1;
    localparam logic [2:0] CMD_NOP       = 3'd2;
    localparam logic [2:0] CMD_EOI_SPEC  = 3'd3;
    localparam logic [2:0] CMD_RAEOI_ON  = 3'd4;
    localparam logic [2:0] CMD_EOI_ROT   = 3'd5;
    localparam logic [2:0] CMD_ROT_SET   = 3'd6;
    localparam logic [2:0] CMD_SPEC_ROT  = 3'd7;

endpackage

// File: rtl/irq_prio_scan.sv
// Finds the first set bit of a vector, searching from a base index
// upward with wrap-around. Assumes N is the number of lines and LW
// is wide enough to hold an index.
module irq_prio_scan #(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input  logic [N-1:0]  vec,
    input  logic [LW-1:0] base,
    output logic          found,
    output logic [LW-1:0] line
);

    // Wrap-around search for the highest-priority set bit.
    always_comb begin
        int idx;
        found = 1'b0;
        line  = '0;
        idx   = 0;
        for (int i = 0; i < N; i++) begin
            idx = (i + int'(base)) % N;
            if (!found && vec[idx]) begin
                found = 1'b1;
                line  = LW'(idx);
            end
        end
    end

endmodule

// File: rtl/irq_seq_fsm.sv
// Setup word sequencer. A restart moves it to expect the second word.
// Data-address writes then step it through the third word and, when
// the restart asked for it, the fourth. Outside setup it flags mask loads.
module irq_seq_fsm
    import irq_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic want_w4,
    input  logic wr_data,
    output logic ld_vec,
    output logic ld_cfg,
    output logic ld_mask,
    output logic busy
);

    seq_st_t st;
    logic    w4_flag;

    // Step decodes for the current data write.
    always_comb begin
        ld_vec  = wr_data && (st == SEQ_W2);
        ld_cfg  = wr_data && (st == SEQ_W4);
        ld_mask = wr_data && (st == SEQ_RUN);
        busy    = (st != SEQ_RUN);
    end

    // Sequencer state and fourth-word flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SEQ_RUN;
            w4_flag <= 1'b0;
        end else if (start) begin
            st      <= SEQ_W2;
            w4_flag <= want_w4;
        end else if (wr_data) begin
            case (st)
                SEQ_W2:  st <= SEQ_W3;
                SEQ_W3:  st <= w4_flag ? SEQ_W4 : SEQ_RUN;
                SEQ_W4:  st <= SEQ_RUN;
                default: st <= SEQ_RUN;
            endcase
        end
    end

endmodule

// File: rtl/irq_cmd_port.sv
// Host register port of an eight-line interrupt controller. It decodes
// setup, mode and end-of-service commands, holds the mask, in-service
// and rotation state, and serves register and poll reads. Assumes a
// separate resolver provides requests and the winning line.
module irq_cmd_port
    import irq_cmd_pkg::*;
#(
    parameter int DW      = 8,
    parameter int N_LINES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [DW-1:0]               bus_wdata,
    output logic [DW-1:0]               bus_rdata,
    input  logic [N_LINES-1:0]          req_vec,
    input  logic                        win_valid,
    input  logic [$clog2(N_LINES)-1:0]  win_line,
    input  logic                        svc_set_en,
    input  logic [$clog2(N_LINES)-1:0]  svc_set_line,
    output logic [N_LINES-1:0]          mask_reg,
    output logic [N_LINES-1:0]          isr_reg,
    output logic [$clog2(N_LINES)-1:0]  rot_base,
    output logic [DW-1:0]               vec_base,
    output logic                        auto_eoi,
    output logic                        nested_mode,
    output logic                        rot_auto_eoi,
    output logic                        special_mask,
    output logic                        poll_mode,
    output logic                        init_busy,
    output logic [N_LINES-1:0]          req_clr,
    output logic                        init_clr,
    output logic                        upd_strobe
);

    localparam int LW = $clog2(N_LINES);
    localparam logic [LW-1:0] IDLE_LINE = LW'(N_LINES - 1);

    logic          wr_cmd, wr_data, is_init, is_mode, is_op, poll_rd;
    logic [2:0]    code;
    logic [LW-1:0] tgt;
    logic          ld_vec, ld_cfg, ld_mask;
    logic          eoi_found;
    logic [LW-1:0] eoi_line;
    logic          rot_ld;
    logic [LW-1:0] rot_nxt;
    logic          op_upd;
    logic [N_LINES-1:0] clr_vec, set_vec;
    logic [DW-LW-1:0]   vb_q;
    logic               rsel;

    // Command classification from the write strobe and data.
    always_comb begin
        wr_cmd  = bus_wr && !bus_addr;
        wr_data = bus_wr && bus_addr;
        is_init = wr_cmd && bus_wdata[4];
        is_mode = wr_cmd && !bus_wdata[4] && bus_wdata[3];
        is_op   = wr_cmd && !bus_wdata[4] && !bus_wdata[3];
        code    = bus_wdata[DW-1:DW-3];
        tgt     = bus_wdata[LW-1:0];
        poll_rd = bus_rd && poll_mode;
    end

    irq_seq_fsm u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (is_init),
        .want_w4 (bus_wdata[0]),
        .wr_data (wr_data),
        .ld_vec  (ld_vec),
        .ld_cfg  (ld_cfg),
        .ld_mask (ld_mask),
        .busy    (init_busy)
    );

    irq_prio_scan #(.N(N_LINES), .LW(LW)) u_scan (
        .vec   (isr_reg),
        .base  (rot_base),
        .found (eoi_found),
        .line  (eoi_line)
    );

    // Rotation base update and update-strobe decode for operation commands.
    always_comb begin
        rot_ld  = 1'b0;
        rot_nxt = rot_base;
        op_upd  = 1'b0;
        if (is_op) begin
            case (code)
                CMD_EOI:      op_upd = 1'b1;
                CMD_EOI_SPEC: op_upd = 1'b1;
                CMD_EOI_ROT: begin
                    op_upd  = 1'b1;
                    rot_ld  = eoi_found;
                    rot_nxt = eoi_line + LW'(1);
                end
                CMD_ROT_SET, CMD_SPEC_ROT: begin
                    op_upd  = 1'b1;
                    rot_ld  = 1'b1;
                    rot_nxt = tgt + LW'(1);
                end
                default: op_upd = 1'b0;
            endcase
        end
    end

    // Per-line in-service clear and set terms.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        always_comb begin
            clr_vec[g] = 1'b0;
            if (is_op && (code == CMD_EOI || code == CMD_EOI_ROT)
                && eoi_found && eoi_line == LW'(g))
                clr_vec[g] = 1'b1;
            if (is_op && (code == CMD_EOI_SPEC || code == CMD_SPEC_ROT)
                && tgt == LW'(g))
                clr_vec[g] = 1'b1;
            if (poll_rd && win_valid && win_line == LW'(g))
                clr_vec[g] = 1'b1;
            set_vec[g] = svc_set_en && (svc_set_line == LW'(g));
        end
    end

    assign vec_base = {vb_q, {LW{1'b0}}};

    // Held registers, mode flags and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || is_init) begin
            mask_reg     <= '0;
            isr_reg      <= '0;
            rot_base     <= '0;
            vb_q         <= '0;
            auto_eoi     <= 1'b0;
            nested_mode  <= 1'b0;
            rot_auto_eoi <= 1'b0;
            special_mask <= 1'b0;
            poll_mode    <= 1'b0;
            rsel         <= 1'b0;
        end else begin
            isr_reg <= (isr_reg & ~clr_vec) | set_vec;
            if (ld_mask) mask_reg <= bus_wdata[N_LINES-1:0];
            if (ld_vec)  vb_q <= bus_wdata[DW-1:LW];
            if (ld_cfg) begin
                nested_mode <= bus_wdata[4];
                auto_eoi    <= bus_wdata[1];
            end
            if (rot_ld) rot_base <= rot_nxt;
            if (is_op && code == CMD_RAEOI_ON)  rot_auto_eoi <= 1'b1;
            if (is_op && code == CMD_RAEOI_OFF) rot_auto_eoi <= 1'b0;
            if (is_mode) begin
                if (bus_wdata[1]) rsel <= bus_wdata[0];
                if (bus_wdata[6]) special_mask <= bus_wdata[5];
            end
            if (is_mode && bus_wdata[2]) poll_mode <= 1'b1;
            else if (poll_rd)            poll_mode <= 1'b0;
        end
    end

    // Registered read data, request clear and update pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            req_clr    <= '0;
            init_clr   <= 1'b0;
            upd_strobe <= 1'b0;
        end else begin
            req_clr    <= poll_rd ? (clr_vec & {N_LINES{win_valid}}) : '0;
            init_clr   <= is_init;
            upd_strobe <= is_init || ld_mask || op_upd || poll_rd;
            if (poll_rd)
                bus_rdata <= DW'(win_valid ? win_line : IDLE_LINE);
            else if (bus_rd)
                bus_rdata <= bus_addr ? DW'(mask_reg)
                           : (rsel ? DW'(isr_reg) : DW'(req_vec));
        end
    end

endmodule

// File: rtl/irq_cmd_port_chk.sv
// Cycle-level property checks for the interrupt command port, bound
// to every instance of the top module.
module irq_cmd_port_chk #(
    parameter int DW = 8,
    parameter int LW = 3,
    parameter int N  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [DW-1:0] bus_wdata,
    input logic [N-1:0]  mask_reg,
    input logic [LW-1:0] rot_base,
    input logic          auto_eoi,
    input logic          rot_auto_eoi,
    input logic          poll_mode,
    input logic          init_busy,
    input logic [N-1:0]  req_clr,
    input logic          upd_strobe
);

    // R2
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4])
        |=> (init_busy && mask_reg == '0 && rot_base == '0 && !auto_eoi));

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && !init_busy)
        |=> (mask_reg == $past(bus_wdata[N-1:0])));

    // R6
    raeoi_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4:3] == 2'b00 && bus_wdata[7:5] == 3'd4)
        |=> rot_auto_eoi);

    // R8
    rot_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4:3] == 2'b00 && bus_wdata[7:5] == 3'd6)
        |=> (rot_base == $past(bus_wdata[LW-1:0]) + LW'(1)));

    // R9
    poll_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && poll_mode && !bus_wr) |=> !poll_mode);

    // R9
    clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clr != '0) |-> $past(bus_rd && poll_mode));

    // R11
    upd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && !init_busy) |=> upd_strobe);

endmodule

bind irq_cmd_port irq_cmd_port_chk #(.DW(DW), .LW(LW), .N(N_LINES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .mask_reg     (mask_reg),
    .rot_base     (rot_base),
    .auto_eoi     (auto_eoi),
    .rot_auto_eoi (rot_auto_eoi),
    .poll_mode    (poll_mode),
    .init_busy    (init_busy),
    .req_clr      (req_clr),
    .upd_strobe   (upd_strobe)
);

// File: tb/sim_irq_cmd_port.sv
`timescale 1ns/1ps
module sim_irq_cmd_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] req_vec = 8'h81;
    logic       win_valid = 1'b0;
    logic [2:0] win_line = '0;
    logic       svc_set_en = 1'b0;
    logic [2:0] svc_set_line = '0;
    logic [7:0] mask_reg, isr_reg, vec_base, req_clr;
    logic [2:0] rot_base;
    logic       auto_eoi, nested_mode, rot_auto_eoi, special_mask;
    logic       poll_mode, init_busy, init_clr, upd_strobe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_cmd_port u0 (.*);

    // Vector: {op(1: read), addr, data, expected read}
    localparam int NV = 12;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h11, 8'h00},
        {1'b0, 1'b1, 8'h48, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'h00},
        {1'b0, 1'b1, 8'h02, 8'h00},
        {1'b0, 1'b1, 8'hA5, 8'h00},
        {1'b1, 1'b1, 8'h00, 8'hA5},
        {1'b0, 1'b1, 8'h3C, 8'h00},
        {1'b1, 1'b1, 8'h00, 8'h3C},
        {1'b0, 1'b0, 8'h0A, 8'h00},
        {1'b1, 1'b0, 8'h00, 8'h81},
        {1'b0, 1'b0, 8'h0B, 8'h00},
        {1'b1, 1'b0, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic svc(input logic [2:0] l);
        @(negedge clk);
        svc_set_line = l; svc_set_en = 1'b1;
        @(negedge clk);
        svc_set_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 mask", mask_reg, 0);
        check("R1 isr", isr_reg, 0);
        check("R1 flags", {auto_eoi, nested_mode, rot_auto_eoi, special_mask,
                           poll_mode, init_busy, init_clr, upd_strobe}, 0);
        check("R1 rdata/rot", {bus_rdata, rot_base, vec_base}, 0);

        // Vector walk: R3 setup with fourth word, R4 mask, R10 reads
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][17]) begin
                rd(VEC[i][16]);
                check("R10 R4 table read", bus_rdata, VEC[i][7:0]);
            end else begin
                wr(VEC[i][16], VEC[i][15:8]);
            end
        end
        check("R3 vector base", vec_base, 8'h48);
        check("R3 fourth word", {nested_mode, auto_eoi}, 2'b01);

        // R2 / R3 setup without fourth word
        wr(1'b0, 8'h10);
        check("R2 busy/pulse", {init_busy, init_clr, upd_strobe}, 3'b111);
        check("R2 cleared", {mask_reg, isr_reg, vec_base, 5'b0, rot_base}, 0);
        check("R2 auto_eoi cleared", auto_eoi, 0);
        wr(1'b1, 8'hFF);
        check("R3 base low bits zero", vec_base, 8'hF8);
        check("R3 still busy", init_busy, 1);
        wr(1'b1, 8'h00);
        check("R3 ends without fourth", init_busy, 0);
        wr(1'b1, 8'h55);
        check("R4 mask load", mask_reg, 8'h55);
        check("R11 strobe after mask", upd_strobe, 1);

        // R12 acknowledge, R7 priority clear
        svc(3'd2); svc(3'd5);
        check("R12 isr set", isr_reg, 8'h24);
        wr(1'b0, 8'h20);
        check("R7 code1 lowest", isr_reg, 8'h20);
        check("R7 rot kept", rot_base, 0);
        check("R11 strobe code1", upd_strobe, 1);
        wr(1'b0, 8'hC4);
        check("R8 code6 rot", rot_base, 5);
        svc(3'd1);
        wr(1'b0, 8'h20);
        check("R7 code1 wrap", isr_reg, 8'h02);
        wr(1'b0, 8'hA0);
        check("R7 code5 isr", isr_reg, 8'h00);
        check("R7 code5 rot", rot_base, 2);
        wr(1'b0, 8'h20);
        check("R7 empty no change", {isr_reg, 5'b0, rot_base}, {8'h00, 8'h02});

        // R8 specific commands
        svc(3'd3); svc(3'd4);
        wr(1'b0, 8'h63);
        check("R8 code3", {isr_reg, 5'b0, rot_base}, {8'h10, 8'h02});
        wr(1'b0, 8'hE4);
        check("R8 code7", {isr_reg, 5'b0, rot_base}, {8'h00, 8'h05});
        wr(1'b0, 8'h40);
        check("R8 code2 nop", {isr_reg, mask_reg, 5'b0, rot_base}, {8'h00, 8'h55, 8'h05});

        // R6 rotate-on-auto-end
        wr(1'b0, 8'h80);
        check("R6 set", rot_auto_eoi, 1);
        check("R11 no strobe code4", upd_strobe, 0);
        wr(1'b0, 8'h00);
        check("R6 clear", {rot_auto_eoi, 5'b0, rot_base}, 9'h005);

        // R5 mode writes
        wr(1'b0, 8'h68);
        check("R5 special mask on", {special_mask, poll_mode}, 2'b10);
        check("R11 no strobe mode", upd_strobe, 0);
        wr(1'b0, 8'h48);
        check("R5 special mask off", special_mask, 0);
        wr(1'b0, 8'h0A);
        rd(1'b0);
        check("R5 R10 request read", bus_rdata, 8'h81);
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h08);
        svc(3'd6);
        rd(1'b0);
        check("R5 select kept", bus_rdata, 8'h40);
        wr(1'b0, 8'h66);

        // R9 poll reads
        svc(3'd3);
        win_valid = 1'b1; win_line = 3'd3;
        wr(1'b0, 8'h0C);
        check("R9 poll armed", poll_mode, 1);
        rd(1'b0);
        check("R9 poll value", bus_rdata, 8'h03);
        check("R9 request clear", req_clr, 8'h08);
        check("R9 isr cleared", isr_reg, 8'h00);
        check("R9 disarmed", {poll_mode, upd_strobe}, 2'b01);
        win_valid = 1'b0;
        wr(1'b0, 8'h0C);
        rd(1'b1);
        check("R9 idle value", bus_rdata, 8'h07);
        check("R9 no clear", req_clr, 8'h00);
        rd(1'b1);
        check("R10 mask read", bus_rdata, 8'h55);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule